// File: doc/BRIEF.md
# Chainable Token-Passing Queue

This block is a first-in first-out queue assembled from a ring of identical storage slices. Each slice owns a small register memory with its own write and read pointers. Two tokens travel around the ring, one for writing and one for reading. Only the slice holding the write token stores incoming words, and only the slice holding the read token presents the oldest word. A slice gives the write token to its successor once it has written its last location. It gives the read token onward once it has read its last location. Capacity therefore grows by adding slices, and no single pointer has to widen.

Both data sides are valid/ready streams. A word enters on a clock edge where `in_valid` and `in_ready` are both high. A word leaves on an edge where `out_valid` and `out_ready` are both high. `out_data` is the oldest stored word whenever `out_valid` is high, and it holds still while the consumer stalls. A producer may hold `in_valid` high with `in_ready` low; the word simply waits. `in_ready` also drops for one cycle while the write token is in flight between slices, and `out_valid` drops likewise for the read token. Three active-low occupancy flags summarise the whole ring.

Top module: `ringq_chain`

## Requirements
- R1: While reset is held, the ring is empty: `empty_n` is 0, `full_n` is 1, `half_n` is 1 and `out_valid` is 0.
- R2: Words leave in exactly the order they were accepted, including across slice boundaries and pointer wrap. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values.
- R3: A word is stored only on an edge where `in_valid` and `in_ready` are both 1. With SLICES*SLICE_DEPTH words held, `in_ready` is 0, and offered words are dropped without changing the contents.
- R4: A word is removed only on an edge where `out_valid` and `out_ready` are both 1. `out_valid` is 0 when the ring is empty, and `out_ready` then has no effect on later output.
- R5: After the write that fills a slice's last location, `in_ready` is 0 for exactly one cycle while the token moves on. From an empty ring just out of reset, a producer holding `in_valid` high fills the ring in SLICES*SLICE_DEPTH + SLICES - 1 cycles.
- R6: The write token stays at a slice whose successor is full. After the first pop from a full ring, `in_ready` is 0 in the following cycle and 1 in the cycle after. A simultaneous write and read on a full ring removes one word and stores none.
- R7: The read token moves on one cycle after a slice's last location is read. Draining a full ring from reset alignment with `out_ready` held takes SLICES*SLICE_DEPTH + SLICES - 1 cycles.
- R8: A word written into an empty ring appears on `out_valid`/`out_data` in the very next cycle. A read requested in the same cycle as that write is ignored.
- R9: The flags are active low and track the total count across all slices, changing in the cycle after the transfer edge. `empty_n`=0 iff the count is 0. `full_n`=0 iff the count is SLICES*SLICE_DEPTH. `half_n`=0 iff the count exceeds SLICES*SLICE_DEPTH/2.
- R10: Slice 0 has its first-load input tied low, so it leaves reset holding both tokens and `in_ready` is 1 during reset. At any time, exactly one slice holds each token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Ring can store a word this cycle |
| in_data | input | WIDTH | Word to store |
| out_valid | output | 1 | `out_data` carries the oldest word |
| out_ready | input | 1 | Consumer takes `out_data` this cycle |
| out_data | output | WIDTH | Oldest stored word |
| empty_n | output | 1 | Low when the ring holds no words |
| half_n | output | 1 | Low when more than half the capacity is used |
| full_n | output | 1 | Low when every location is used |

## Verification
The flags, `out_valid` and `out_data` are all driven from registered counts and pointers, so a transfer on one edge is visible on them just after that edge. The bench therefore compares them against its queue model one half-cycle later, before driving the next stimulus. `in_ready` and `out_valid` do not depend on the same-cycle `in_valid`/`out_ready`, so the bench samples them after driving its inputs to decide which transfers fire at the coming edge. A token handoff costs exactly one cycle of lost readiness. The bench counts the cycles taken by a clean fill and a clean drain, and it probes readiness in the first and second cycles after a pop from a full ring.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // write and read tokens travelling together on one ring link
  typedef struct packed {
    logic w;
    logic r;
  } ringq_tok_t;

  function automatic int ptr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ringq_store.sv
module ringq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/ringq_slice.sv
module ringq_slice
  import ringq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int AW    = ringq_pkg::ptr_bits(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  ringq_tok_t       xi,
  output ringq_tok_t       xo,
  input  logic             nxt_free,
  output logic             free,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ok,
  input  logic             rd_req,
  output logic             rd_ok,
  output logic [WIDTH-1:0] rd_data,
  output logic             own_w,
  output logic             own_r,
  output logic [CW-1:0]    occ
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic          wtok, wdone, rtok, rdone;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          wr_fire, rd_fire;

  assign wr_ok   = wtok && !wdone && (cnt != FULLV);
  assign rd_ok   = rtok && !rdone && (cnt != '0);
  assign wr_fire = wr_req && wr_ok;
  assign rd_fire = rd_req && rd_ok;
  assign free    = (cnt != FULLV);
  // a spent write token leaves only when the successor has room
  assign xo.w    = wtok && wdone && nxt_free;
  assign xo.r    = rtok && rdone;
  assign own_w   = wtok;
  assign own_r   = rtok;
  assign occ     = cnt;

  ringq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .we   (wr_fire),
    .waddr(wptr),
    .wdata(wr_data),
    .raddr(rptr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wtok  <= !first_n;
      wdone <= 1'b0;
      wptr  <= '0;
    end else begin
      if (wr_fire) begin
        if (wptr == LAST) begin
          wptr  <= '0;
          wdone <= 1'b1;
        end else begin
          wptr <= wptr + 1'b1;
        end
      end
      if (xo.w) wtok <= 1'b0;
      if (xi.w) begin
        wtok  <= 1'b1;
        wdone <= 1'b0;
        wptr  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtok  <= !first_n;
      rdone <= 1'b0;
      rptr  <= '0;
    end else begin
      if (rd_fire) begin
        if (rptr == LAST) begin
          rptr  <= '0;
          rdone <= 1'b1;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
      if (xo.r) rtok <= 1'b0;
      if (xi.r) begin
        rtok  <= 1'b1;
        rdone <= 1'b0;
        rptr  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CW'(wr_fire) - CW'(rd_fire);
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULLV);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cnt != '0));

endmodule

// File: rtl/ringq_flags.sv
module ringq_flags #(
  parameter int SLICES = 4,
  parameter int CW     = 3,
  parameter int TOTAL  = 16
) (
  input  logic [CW-1:0] occ [SLICES],
  output logic          empty_n,
  output logic          half_n,
  output logic          full_n
);

  localparam int TW = $clog2(TOTAL + 1);
  localparam logic [TW-1:0] CAPV  = TW'(TOTAL);
  localparam logic [TW-1:0] HALFV = TW'(TOTAL / 2);

  logic [TW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < SLICES; i++) sum = sum + TW'(occ[i]);
  end

  assign empty_n = (sum != '0);
  assign full_n  = (sum != CAPV);
  assign half_n  = !(sum > HALFV);

endmodule

// File: rtl/ringq_chain.sv
module ringq_chain
  import ringq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SLICE_DEPTH = 4,
  parameter int SLICES      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);

  localparam int AW    = ringq_pkg::ptr_bits(SLICE_DEPTH);
  localparam int CW    = $clog2(SLICE_DEPTH + 1);
  localparam int TOTAL = SLICES * SLICE_DEPTH;

  ringq_tok_t        ring   [SLICES];
  logic [WIDTH-1:0]  rdat   [SLICES];
  logic [CW-1:0]     occ    [SLICES];
  logic [SLICES-1:0] free_v, wok_v, rok_v, ownw_v, ownr_v;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    localparam int PREV = (g + SLICES - 1) % SLICES;
    localparam int NEXT = (g + 1) % SLICES;

    ringq_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH), .AW(AW), .CW(CW)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .first_n (g != 0),
      .xi      (ring[PREV]),
      .xo      (ring[g]),
      .nxt_free(free_v[NEXT]),
      .free    (free_v[g]),
      .wr_req  (in_valid),
      .wr_data (in_data),
      .wr_ok   (wok_v[g]),
      .rd_req  (out_ready),
      .rd_ok   (rok_v[g]),
      .rd_data (rdat[g]),
      .own_w   (ownw_v[g]),
      .own_r   (ownr_v[g]),
      .occ     (occ[g])
    );
  end

  assign in_ready  = |wok_v;
  assign out_valid = |rok_v;

  always_comb begin
    out_data = '0;
    for (int i = 0; i < SLICES; i++)
      if (ownr_v[i]) out_data = out_data | rdat[i];
  end

  ringq_flags #(.SLICES(SLICES), .CW(CW), .TOTAL(TOTAL)) u_flags (
    .occ    (occ),
    .empty_n(empty_n),
    .half_n (half_n),
    .full_n (full_n)
  );

  assert_one_wtok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ownw_v));

  assert_one_rtok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ownr_v));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !in_ready);

  assert_empty_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_flag_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);

endmodule

// File: tb/ringq_chain_test.sv
module ringq_chain_test;

  localparam int W   = 8;
  localparam int D   = 4;
  localparam int N   = 4;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, out_ready;
  logic [W-1:0] in_data;
  logic         in_ready, out_valid, empty_n, half_n, full_n;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  ringq_chain #(.WIDTH(W), .SLICE_DEPTH(D), .SLICES(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  int           checks = 0;
  int           errors = 0;
  bit           finished = 0;
  bit           last_w, last_r;
  logic [W-1:0] q[$];
  logic [W-1:0] dat = 8'h10;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // compare every observable output with the queue model
  task automatic look();
    int sz = q.size();
    chk(empty_n == (sz != 0), "R9 empty_n", int'(empty_n), int'(sz != 0));
    chk(full_n == (sz != CAP), "R9 full_n", int'(full_n), int'(sz != CAP));
    chk(half_n == !(sz > CAP / 2), "R9 half_n", int'(half_n), int'(!(sz > CAP / 2)));
    if (out_valid) begin
      chk(sz > 0, "R4 out_valid while empty", sz, 1);
      if (sz > 0) chk(out_data == q[0], "R2 out_data order", int'(out_data), int'(q[0]));
    end
    if (in_ready) chk(sz < CAP, "R3 in_ready while full", sz, CAP - 1);
  endtask

  task automatic step(input bit iv, input logic [W-1:0] id, input bit ordy);
    look();
    in_valid  = iv;
    in_data   = id;
    out_ready = ordy;
    #1;
    last_w = iv && in_ready;
    last_r = ordy && out_valid;
    @(posedge clk);
    if (last_r) void'(q.pop_front());
    if (last_w) q.push_back(id);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_data = '0;
    q.delete();
    repeat (3) @(negedge clk);
    chk(empty_n == 1'b0, "R1 empty_n in reset", int'(empty_n), 0);
    chk(full_n == 1'b1, "R1 full_n in reset", int'(full_n), 1);
    chk(half_n == 1'b1, "R1 half_n in reset", int'(half_n), 1);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10 first slice holds write token", int'(in_ready), 1);
    rst_n = 1'b1;
  endtask

  task automatic clean_fill();
    int n = 0;
    int cyc = 0;
    while (n < CAP && cyc < 60) begin
      step(1'b1, dat, 1'b0);
      cyc++;
      if (last_w) begin
        n++;
        dat++;
      end
    end
    chk(cyc == CAP + N - 1, "R5 fill cycles", cyc, CAP + N - 1);
  endtask

  initial begin
    do_reset();

    // clean fill, then offers into a full ring
    clean_fill();
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 8'hEE, 1'b0);
      chk(!last_w, "R3 write to full ring accepted", int'(last_w), 0);
    end

    // first pop from full: write token moves only now
    step(1'b0, '0, 1'b1);
    chk(last_r, "R6 pop from full", int'(last_r), 1);
    chk(in_ready == 1'b0, "R6 token in flight", int'(in_ready), 0);
    step(1'b0, '0, 1'b0);
    chk(in_ready == 1'b1, "R6 token arrived", int'(in_ready), 1);
    step(1'b1, dat, 1'b0);
    dat++;
    step(1'b1, dat, 1'b1);
    chk(!last_w && last_r, "R6 simultaneous at full", int'({last_w, last_r}), 1);
    step(1'b1, dat, 1'b1);
    chk(last_w && last_r, "R6 simultaneous below full", int'({last_w, last_r}), 3);
    dat++;

    // drain, then reads on an empty ring
    for (int i = 0; i < 60 && q.size() > 0; i++) step(1'b0, '0, 1'b1);
    chk(q.size() == 0, "R2 drain completes", q.size(), 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0, 1'b1);
      chk(!last_r, "R4 read of empty ring", int'(last_r), 0);
    end
    step(1'b0, '0, 1'b0);
    step(1'b1, dat, 1'b1);
    chk(last_w && !last_r, "R8 simultaneous at empty", int'({last_w, last_r}), 2);
    chk(out_valid == 1'b1, "R8 next-cycle presentation", int'(out_valid), 1);
    dat++;
    step(1'b0, '0, 1'b1);
    chk(last_r, "R8 word popped", int'(last_r), 1);

    // clean drain timing from reset alignment
    do_reset();
    clean_fill();
    begin
      int n = 0;
      int cyc = 0;
      while (n < CAP && cyc < 60) begin
        step(1'b0, '0, 1'b1);
        cyc++;
        if (last_r) n++;
      end
      chk(cyc == CAP + N - 1, "R7 drain cycles", cyc, CAP + N - 1);
    end

    // mixed traffic in phases of differing pressure
    for (int ph = 0; ph < 4; ph++) begin
      int pw = (ph == 0) ? 75 : (ph == 1) ? 30 : (ph == 2) ? 55 : 90;
      int pr = (ph == 0) ? 35 : (ph == 1) ? 75 : (ph == 2) ? 55 : 90;
      for (int i = 0; i < 1000; i++) begin
        bit iv = ($urandom % 100) < pw;
        bit rv = ($urandom % 100) < pr;
        logic [W-1:0] d = W'($urandom);
        step(iv, d, rv);
      end
    end
    for (int i = 0; i < 80 && q.size() > 0; i++) step(1'b0, '0, 1'b1);
    chk(q.size() == 0, "R2 final drain", q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-requirements act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule